// File: doc/BRIEF.md
# Configurable Timer Counter with Prescaler

This block is an up-counting timer that software sets up through one control byte. It can count strobes from the internal instruction-cycle tick or edges on an external pin, and the control byte chooses which edge of that pin counts. A power-of-two prescaler can divide the selected ticks, or it can be bypassed. The counter is either 8 or 16 bits wide, and the width sets the point at which it overflows.

Each rollover sets a sticky overflow flag. Only software clears it. The interrupt request output is the flag gated by a local enable and a global enable. The external pin passes through a two-flop synchroniser inside the block, so the pin may be fully asynchronous to the clock. Software can write the count directly. Writing the count or the control byte restarts the prescaler.

Top module: `cfg_timer`

## Requirements
- R1: After reset, the control byte reads 0x00, the count reads 0, and both the overflow flag and the interrupt output are low.
- R2: Control bit 0 (run) lets the counter advance when it is 1. When it is 0, the count holds its value no matter what arrives on the tick or pin inputs.
- R3: When control bit 1 (narrow) is 1, only count bits 7:0 advance, bits 15:8 hold, and overflow is the step from 0xFF to 0x00 in the low byte. When the bit is 0, all 16 bits advance and overflow is the step from 0xFFFF to 0x0000, so a step from 0x00FF to 0x0100 raises no flag.
- R4: When control bit 2 (source) is 0, the counter uses `tick_i` strobes. When it is 1, it uses edges of `ext_pin_i`, which are seen after two synchroniser flops, and `tick_i` is ignored. At most one count event occurs per clock.
- R5: When control bit 3 (edge) is 0, rising edges of the pin count. When it is 1, falling edges count.
- R6: When control bit 4 (bypass) is 1, every selected event advances the count by one in the clock that samples it.
- R7: When bypass is 0, control bits 7:5 hold a code c, and the count advances once per 2^(c+1) selected events: 000 divides by 2 and 111 divides by 256.
- R8: Overflow sets the flag, and only a flag write clears it. If an overflow and a flag write happen in the same clock, the flag ends up set.
- R9: The interrupt output is high exactly one clock after a cycle in which the flag, `tmr_ie_i` and `glb_ie_i` are all high.
- R10: A count write loads the value at the next clock edge and takes priority over counting. A count write or a control write clears the prescaler's partial count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Internal instruction-cycle strobe |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write value |
| flag_we | input | 1 | Overflow flag write strobe |
| flag_wdata | input | 1 | Overflow flag write value |
| tmr_ie_i | input | 1 | Local timer interrupt enable |
| glb_ie_i | input | 1 | Global interrupt enable |
| ctrl_o | output | 8 | Current control byte |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Assertions check the following on every cycle:
- the count holds while run is low;
- both rollover shapes, including the unchanged high byte in narrow mode;
- a count write loads on the next clock;
- the flag stays set and wins over a simultaneous clear;
- the interrupt output follows its three gates;
- the prescaler never gives two consecutive increments;
- the edge detector never gives two consecutive events for one pin transition.

Only the directed scenarios can show the end-to-end results:
- the exact division ratio for a given code;
- pin edges being counted for the chosen polarity through the synchroniser;
- the internal tick being ignored when the pin is the source;
- a partly filled prescaler being discarded after a write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Control byte layout. The prescale code sits in the top bits.
  typedef struct packed {
    logic [2:0] ps_code;
    logic       bypass;
    logic       fall_edge;
    logic       src_ext;
    logic       narrow;
    logic       run;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  // sh[STAGES-1] is the synchronised pin and sh[STAGES] is its previous value.
  logic [STAGES:0] sh_q;
  logic            sync_cur;
  logic            sync_prev;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign sync_cur  = sh_q[STAGES-1];
  assign sync_prev = sh_q[STAGES];
  assign edge_o    = fall_i ? (sync_prev & ~sync_cur) : (sync_cur & ~sync_prev);

  // R4: one pin transition gives at most one event.
  p_edge_single_r4: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> (!edge_o || (fall_i != $past(fall_i))));

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            tick_i,
  input  logic            bypass_i,
  input  logic [PS_W-1:0] code_i,
  output logic            inc_o
);
  localparam int PCNT_W = 2 ** PS_W;

  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] mask;
  logic              terminal;

  // Code c uses the low c+1 bits of the divider.
  always_comb begin
    for (int i = 0; i < PCNT_W; i++) mask[i] = (i <= int'(code_i));
  end

  assign terminal = &(pcnt_q | ~mask);

  always_ff @(posedge clk) begin
    if (rst || clr_i)          pcnt_q <= '0;
    else if (tick_i && !bypass_i) pcnt_q <= pcnt_q + 1'b1;
  end

  assign inc_o = bypass_i ? tick_i : (tick_i & terminal);

  // R7: the smallest ratio is 2, so a divided increment is never followed at once by another.
  p_div_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (inc_o && !bypass_i) |=> (!inc_o || bypass_i));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             narrow_i,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int HI_W = CNT_W - NARROW_W;

  logic [CNT_W-1:0] count_q;
  logic             step;
  logic             at_max;

  assign step   = run_i & inc_i;
  assign at_max = narrow_i ? (&count_q[NARROW_W-1:0]) : (&count_q);
  assign ovf_o  = step & at_max & ~load_i;

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (step) begin
      if (narrow_i) count_q <= {count_q[CNT_W-1:NARROW_W], count_q[NARROW_W-1:0] + 1'b1};
      else          count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;

  // R2
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> $stable(count_q));
  // R3
  p_wrap_narrow_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && narrow_i) |=> (count_q[NARROW_W-1:0] == '0) &&
                            (count_q[CNT_W-1:NARROW_W] == $past(count_q[CNT_W-1:NARROW_W])));
  // R3
  p_wrap_wide_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !narrow_i) |=> (count_q == '0));
  // R10
  p_load_next_r10: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (count_q == $past(load_val_i)));

  initial begin
    assert (HI_W > 0) else $error("narrow width must be below full width");
  end

endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NARROW_W    = 8,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ext_pin_i,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             flag_we,
  input  logic             flag_wdata,
  input  logic             tmr_ie_i,
  input  logic             glb_ie_i,
  output logic [7:0]       ctrl_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  tmr_ctrl_t ctrl_q;
  logic      pin_edge;
  logic      src_evt;
  logic      gated_evt;
  logic      inc;
  logic      ovf;
  logic      flag_q;
  logic      irq_q;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= tmr_ctrl_t'(ctrl_wdata);
  end

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (ext_pin_i),
    .fall_i (ctrl_q.fall_edge),
    .edge_o (pin_edge)
  );

  assign src_evt   = ctrl_q.src_ext ? pin_edge : tick_i;
  assign gated_evt = src_evt & ctrl_q.run;

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (ctrl_we | cnt_we),
    .tick_i   (gated_evt),
    .bypass_i (ctrl_q.bypass),
    .code_i   (ctrl_q.ps_code),
    .inc_o    (inc)
  );

  tmr_count_core #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .run_i      (ctrl_q.run),
    .narrow_i   (ctrl_q.narrow),
    .inc_i      (inc),
    .load_i     (cnt_we),
    .load_val_i (cnt_wdata),
    .count_o    (count_o),
    .ovf_o      (ovf)
  );

  // An overflow set wins over a software write in the same clock.
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (ovf)     flag_q <= 1'b1;
    else if (flag_we) flag_q <= flag_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_q & tmr_ie_i & glb_ie_i;
  end

  assign ctrl_o     = ctrl_q;
  assign ovf_flag_o = flag_q;
  assign irq_o      = irq_q;

  // R8
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_we) |=> flag_q);
  // R8
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag_q);
  // R9
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(flag_q && tmr_ie_i && glb_ie_i));
  // R9
  p_irq_raise_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && tmr_ie_i && glb_ie_i) |=> irq_o);

endmodule

// File: tb/cfg_timer_test.sv
`timescale 1ns/1ps
module cfg_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0, ext_pin_i = 1'b0;
  logic        ctrl_we = 1'b0, cnt_we = 1'b0, flag_we = 1'b0, flag_wdata = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [15:0] cnt_wdata = '0;
  logic        tmr_ie_i = 1'b0, glb_ie_i = 1'b0;
  logic [7:0]  ctrl_o;
  logic [15:0] count_o;
  logic        ovf_flag_o, irq_o;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  cfg_timer uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ext_pin_i(ext_pin_i),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .tmr_ie_i(tmr_ie_i), .glb_ie_i(glb_ie_i),
    .ctrl_o(ctrl_o), .count_o(count_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Control byte fields: [0] run, [1] narrow, [2] source, [3] edge, [4] bypass, [7:5] code.
  function automatic logic [7:0] mk(input bit run, input bit nar, input bit ext,
                                    input bit fall, input bit byp, input logic [2:0] ps);
    return {ps, byp, fall, ext, nar, run};
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic wr_flag(input logic v);
    @(negedge clk); flag_we = 1'b1; flag_wdata = v;
    @(negedge clk); flag_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_o, 0);
    chk("R1 count", count_o, 0);
    chk("R1 flag", ovf_flag_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_run_hold();
    wr_ctrl(mk(0, 0, 0, 0, 1, 3'd0));
    wr_cnt(16'd5);
    chk("R10 load", count_o, 5);
    ticks(10);
    chk("R2 stopped hold", count_o, 5);
  endtask

  task automatic t_bypass();
    wr_ctrl(mk(1, 0, 0, 0, 1, 3'd0));
    wr_cnt(16'd0);
    ticks(7);
    chk("R6 bypass count", count_o, 7);
  endtask

  task automatic t_prescale(input logic [2:0] c);
    int r;
    r = 1 << (int'(c) + 1);
    wr_ctrl(mk(1, 0, 0, 0, 0, c));
    wr_cnt(16'd0);
    ticks(3 * r + r - 1);
    chk("R7 prescale ratio", count_o, 3);
  endtask

  task automatic t_pre_clear();
    wr_ctrl(mk(1, 0, 0, 0, 0, 3'd1));
    wr_cnt(16'd0);
    ticks(3);
    chk("R10 partial prescale", count_o, 0);
    wr_cnt(16'h0010);
    ticks(3);
    chk("R10 prescaler cleared by count write", count_o, 16'h0010);
    ticks(1);
    chk("R10 first increment after clear", count_o, 16'h0011);
  endtask

  task automatic t_wrap16();
    wr_ctrl(mk(1, 0, 0, 0, 1, 3'd0));
    wr_cnt(16'h00FF);
    wr_flag(1'b0);
    ticks(1);
    chk("R3 wide carry", count_o, 16'h0100);
    chk("R3 no flag at 0xFF in wide", ovf_flag_o, 0);
    wr_cnt(16'hFFFE);
    ticks(1);
    chk("R3 wide before wrap", ovf_flag_o, 0);
    ticks(1);
    chk("R3 wide wrap", count_o, 0);
    chk("R3 wide flag", ovf_flag_o, 1);
  endtask

  task automatic t_wrap8();
    wr_flag(1'b0);
    wr_ctrl(mk(1, 1, 0, 0, 1, 3'd0));
    wr_cnt(16'h12FE);
    ticks(1);
    chk("R3 narrow before wrap", ovf_flag_o, 0);
    ticks(1);
    chk("R3 narrow wrap keeps high byte", count_o, 16'h1200);
    chk("R3 narrow flag", ovf_flag_o, 1);
    ticks(4);
    chk("R8 flag sticky", ovf_flag_o, 1);
  endtask

  task automatic t_set_wins();
    // The flag is already set here, and an overflow meets a clear in one clock.
    wr_cnt(16'h00FF);
    @(negedge clk); tick_i = 1'b1; flag_we = 1'b1; flag_wdata = 1'b0;
    @(negedge clk); tick_i = 1'b0; flag_we = 1'b0;
    chk("R8 set beats clear", ovf_flag_o, 1);
    chk("R8 wrap in collision", count_o, 16'h0000);
    wr_flag(1'b0);
    chk("R8 software clear", ovf_flag_o, 0);
  endtask

  task automatic t_irq();
    wr_flag(1'b1);
    @(negedge clk); tmr_ie_i = 1'b1; glb_ie_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 global gate off", irq_o, 0);
    glb_ie_i = 1'b1;
    @(negedge clk);
    chk("R9 irq raised", irq_o, 1);
    tmr_ie_i = 1'b0;
    @(negedge clk);
    chk("R9 local gate off", irq_o, 0);
    tmr_ie_i = 1'b1;
    wr_flag(1'b0);
    @(negedge clk);
    chk("R9 flag cleared drops irq", irq_o, 0);
    tmr_ie_i = 1'b0; glb_ie_i = 1'b0;
  endtask

  task automatic pin_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ext_pin_i = 1'b1;
      repeat (4) @(negedge clk);
      ext_pin_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ext(input bit fall);
    wr_ctrl(mk(1, 0, 1, fall, 1, 3'd0));
    wr_cnt(16'd0);
    ticks(6);
    chk("R4 tick ignored in pin mode", count_o, 0);
    pin_pulses(5);
    chk(fall ? "R5 falling edges" : "R4 rising edges", count_o, 5);
  endtask

  task automatic t_ext_latency();
    wr_ctrl(mk(1, 0, 1, 0, 1, 3'd0));
    wr_cnt(16'd0);
    @(negedge clk); ext_pin_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R4 sync not yet", count_o, 0);
    @(negedge clk);
    chk("R4 sync latency", count_o, 1);
    repeat (4) @(negedge clk);
    chk("R4 single event per edge", count_o, 1);
    ext_pin_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_run_hold();
    t_bypass();
    t_prescale(3'd0);
    t_prescale(3'd2);
    t_prescale(3'd7);
    t_pre_clear();
    t_wrap16();
    t_wrap8();
    t_set_wins();
    t_irq();
    t_ext(1'b0);
    t_ext(1'b1);
    t_ext_latency();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule